// File: doc/BRIEF.md
# Two-Level Interrupt Flag and Enable Controller

This block collects one-cycle event pulses from three core sources and five peripheral sources and turns them into a single interrupt request for the processor. The core sources are a timer0 overflow, an external edge and a port change. The peripheral sources are low-voltage detect, ADC conversion done, two comparators and a timer1 overflow.

Each event sets a sticky flag, whatever the state of the enables. A core source reaches the request through its own enable and the global enable. A peripheral source must also pass a group enable, so it needs three enables in all.

Software reads and writes three 8-bit registers over a small synchronous bus. The processor gives two strobes. One says an interrupt has been taken, which drops the global enable. The other says an interrupt routine has returned, which raises the global enable again.

Top module: `irq_agg_top`

## Requirements
- R1: After synchronous reset every enable bit, every flag and the global enable read 0, and `irq` is low.
- R2: The core register sits at address 0. Its bits are, from bit 7 down: global enable, peripheral group enable, timer0 enable, external enable, port-change enable, timer0 flag, external flag, port-change flag. `core_evt[2]`, `core_evt[1]` and `core_evt[0]` set bits 2, 1 and 0 respectively.
- R3: The peripheral flag register is at address 1 and the peripheral enable register is at address 2. In both, bit 7 is low-voltage, bit 6 is ADC, bit 5 is comparator B, bit 4 is comparator A and bit 0 is timer1. Bits 3..1 always read 0 and ignore writes. `periph_evt[4:0]` map to bits 7, 6, 5, 4 and 0 in that order.
- R4: An event pulse sets its flag on the next clock edge, whatever the individual, group or global enables hold.
- R5: A flag keeps its value until a bus write to its register loads a new value. Writing 0 clears the flag and writing 1 sets it.
- R6: When an event and a bus write of 0 hit the same flag in the same cycle, the flag ends up set.
- R7: `irq` is high when the global enable is 1 and some core source has both its enable and its flag at 1.
- R8: A peripheral source drives `irq` only when its own enable, the group enable and the global enable are all 1.
- R9: While the global enable is 0, `irq` stays low whatever the flags and the other enables hold.
- R10: `cpu_ack` clears the global enable on the next edge and `cpu_reti` sets it. If both arrive in the same cycle, the acknowledge wins. Both strobes win over a bus write to bit 7 in the same cycle, while the rest of that write still takes effect.
- R11: Address 3 reads 0, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| core_evt | input | 3 | Core event pulses: [2] timer0, [1] external, [0] port change |
| periph_evt | input | 5 | Peripheral event pulses: [4] low-voltage, [3] ADC, [2] comparator B, [1] comparator A, [0] timer1 |
| bus_addr | input | 2 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register, combinational |
| cpu_ack | input | 1 | Interrupt taken strobe |
| cpu_reti | input | 1 | Return from interrupt strobe |
| irq | output | 1 | Interrupt request to the processor |

## Verification
Two pairs of actions can land on the same register bit in one cycle, and the bench drives both pairs on purpose.

The first pair is a hardware event and a software clear of the same flag. The bench pulses a peripheral event in the same cycle as a bus write of zero to the flag register. It then expects the flag to read back as set.

The second pair is the processor strobes and a software write of the global enable bit. The bench issues the acknowledge together with return, and again together with a bus write that sets bit 7. It expects the global enable to read 0 in both cases, while the other written bits still land. A behavioural model tracks every register and compares both `irq` and read data every cycle.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int REG_W        = 8;
    localparam int ADDR_W       = 2;
    localparam int CORE_SRC_N   = 3;
    localparam int PERIPH_SRC_N = 5;
    localparam int CORE_EN_W    = CORE_SRC_N + 1;

    // Implemented bits of the peripheral flag and enable registers.
    localparam logic [REG_W-1:0] PERIPH_IMPL = 8'hF1;

    typedef enum logic [ADDR_W-1:0] {
        SEL_CORE  = 2'd0,
        SEL_PFLAG = 2'd1,
        SEL_PEN   = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    // Core register image, bit 7 first.
    typedef struct packed {
        logic                  glb;
        logic                  grp;
        logic [CORE_SRC_N-1:0] src_en;
        logic [CORE_SRC_N-1:0] src_flag;
    } core_reg_t;

    typedef struct packed {
        logic core;
        logic pflag;
        logic pen;
    } wr_strobe_t;

    // Place the peripheral event pulses on their register bit positions.
    function automatic logic [REG_W-1:0] periph_evt_to_reg(input logic [PERIPH_SRC_N-1:0] e);
        return {e[4], e[3], e[2], e[1], 3'b000, e[0]};
    endfunction

    function automatic wr_strobe_t decode_write(input logic we, input logic [ADDR_W-1:0] a);
        wr_strobe_t s;
        s.core  = we && (reg_sel_e'(a) == SEL_CORE);
        s.pflag = we && (reg_sel_e'(a) == SEL_PFLAG);
        s.pen   = we && (reg_sel_e'(a) == SEL_PEN);
        return s;
    endfunction

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int             W    = 8,
    parameter logic [W-1:0]   IMPL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_vec,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] flags
);
    logic unused_bits;
    assign unused_bits = ^((set_vec | wr_data) & ~IMPL);

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (IMPL[i]) begin : g_impl
            logic q;
            always_ff @(posedge clk) begin
                if (rst)
                    q <= 1'b0;
                else if (set_vec[i])
                    q <= 1'b1;          // hardware set beats software write
                else if (wr_en)
                    q <= wr_data[i];
            end
            assign flags[i] = q;
        end else begin : g_tie
            assign flags[i] = 1'b0;
        end
    end
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
    parameter int           W    = 8,
    parameter logic [W-1:0] IMPL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] en
);
    logic unused_bits;
    assign unused_bits = ^(wr_data & ~IMPL);

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (IMPL[i]) begin : g_impl
            logic q;
            always_ff @(posedge clk) begin
                if (rst)
                    q <= 1'b0;
                else if (wr_en)
                    q <= wr_data[i];
            end
            assign en[i] = q;
        end else begin : g_tie
            assign en[i] = 1'b0;
        end
    end
endmodule

// File: rtl/irq_global_ctl.sv
module irq_global_ctl (
    input  logic clk,
    input  logic rst,
    input  logic cpu_ack,
    input  logic cpu_reti,
    input  logic wr_en,
    input  logic wr_bit,
    output logic glb_en
);
    always_ff @(posedge clk) begin
        if (rst)
            glb_en <= 1'b0;
        else if (cpu_ack)
            glb_en <= 1'b0;
        else if (cpu_reti)
            glb_en <= 1'b1;
        else if (wr_en)
            glb_en <= wr_bit;
    end
endmodule

// File: rtl/irq_req_combine.sv
module irq_req_combine
    import irq_agg_pkg::*;
(
    input  core_reg_t        core_q,
    input  logic [REG_W-1:0] pflag,
    input  logic [REG_W-1:0] pen,
    output logic             irq
);
    logic core_hit;
    logic periph_hit;

    always_comb begin
        core_hit   = |(core_q.src_en & core_q.src_flag);
        periph_hit = core_q.grp & (|(pen & pflag));
        irq        = core_q.glb & (core_hit | periph_hit);
    end
endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
    import irq_agg_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic [CORE_SRC_N-1:0]   core_evt,
    input  logic [PERIPH_SRC_N-1:0] periph_evt,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic                    bus_we,
    input  logic [REG_W-1:0]        bus_wdata,
    output logic [REG_W-1:0]        bus_rdata,
    input  logic                    cpu_ack,
    input  logic                    cpu_reti,
    output logic                    irq
);
    wr_strobe_t             wr;
    core_reg_t              core_q;
    logic [CORE_SRC_N-1:0]  core_flags;
    logic [CORE_EN_W-1:0]   core_en;
    logic                   glb_en;
    logic [REG_W-1:0]       pflag;
    logic [REG_W-1:0]       pen;
    core_reg_t              core_wr;

    assign wr      = decode_write(bus_we, bus_addr);
    assign core_wr = core_reg_t'(bus_wdata);

    irq_flag_bank #(.W(CORE_SRC_N), .IMPL('1)) u_core_flags (
        .clk(clk), .rst(rst), .set_vec(core_evt),
        .wr_en(wr.core), .wr_data(core_wr.src_flag), .flags(core_flags)
    );

    irq_enable_reg #(.W(CORE_EN_W), .IMPL('1)) u_core_en (
        .clk(clk), .rst(rst), .wr_en(wr.core),
        .wr_data({core_wr.grp, core_wr.src_en}), .en(core_en)
    );

    irq_global_ctl u_glb (
        .clk(clk), .rst(rst), .cpu_ack(cpu_ack), .cpu_reti(cpu_reti),
        .wr_en(wr.core), .wr_bit(core_wr.glb), .glb_en(glb_en)
    );

    irq_flag_bank #(.W(REG_W), .IMPL(PERIPH_IMPL)) u_pflags (
        .clk(clk), .rst(rst), .set_vec(periph_evt_to_reg(periph_evt)),
        .wr_en(wr.pflag), .wr_data(bus_wdata), .flags(pflag)
    );

    irq_enable_reg #(.W(REG_W), .IMPL(PERIPH_IMPL)) u_pen (
        .clk(clk), .rst(rst), .wr_en(wr.pen), .wr_data(bus_wdata), .en(pen)
    );

    always_comb begin
        core_q.glb      = glb_en;
        core_q.grp      = core_en[CORE_EN_W-1];
        core_q.src_en   = core_en[CORE_SRC_N-1:0];
        core_q.src_flag = core_flags;
    end

    always_comb begin
        unique case (reg_sel_e'(bus_addr))
            SEL_CORE:  bus_rdata = core_q;
            SEL_PFLAG: bus_rdata = pflag;
            SEL_PEN:   bus_rdata = pen;
            default:   bus_rdata = '0;
        endcase
    end

    irq_req_combine u_comb (
        .core_q(core_q), .pflag(pflag), .pen(pen), .irq(irq)
    );
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
    import irq_agg_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic [CORE_SRC_N-1:0]   core_evt,
    input logic [PERIPH_SRC_N-1:0] periph_evt,
    input logic [ADDR_W-1:0]       bus_addr,
    input logic                    bus_we,
    input logic [REG_W-1:0]        bus_rdata,
    input logic                    cpu_ack,
    input logic                    cpu_reti,
    input logic                    irq,
    input core_reg_t               core_q,
    input logic [REG_W-1:0]        pflag,
    input logic [REG_W-1:0]        pen
);
    assert_core_evt_sets_R4: assert property (@(posedge clk) disable iff (rst)
        core_evt[2] |=> core_q.src_flag[2]);

    assert_periph_evt_sets_R4: assert property (@(posedge clk) disable iff (rst)
        periph_evt[4] |=> pflag[7]);

    assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && bus_addr == 2'd1) |=> ((pflag | ~$past(pflag)) == 8'hFF));

    assert_set_beats_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (periph_evt[0] && bus_we && bus_addr == 2'd1) |=> pflag[0]);

    assert_group_gate_R8: assert property (@(posedge clk) disable iff (rst)
        (irq && !(|(core_q.src_en & core_q.src_flag))) |-> core_q.grp);

    assert_glb_blocks_R9: assert property (@(posedge clk) disable iff (rst)
        !core_q.glb |-> !irq);

    assert_ack_clears_R10: assert property (@(posedge clk) disable iff (rst)
        cpu_ack |=> !core_q.glb);

    assert_reti_sets_R10: assert property (@(posedge clk) disable iff (rst)
        (cpu_reti && !cpu_ack) |=> core_q.glb);

    assert_unimpl_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 2'd1 || bus_addr == 2'd2) |-> (bus_rdata[3:1] == 3'b000));

    assert_addr3_zero_R11: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 2'd3) |-> (bus_rdata == 8'h00));
endmodule

bind irq_agg_top irq_agg_chk u_chk (
    .clk(clk), .rst(rst), .core_evt(core_evt), .periph_evt(periph_evt),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_rdata(bus_rdata),
    .cpu_ack(cpu_ack), .cpu_reti(cpu_reti), .irq(irq),
    .core_q(core_q), .pflag(pflag), .pen(pen)
);

// File: tb/irq_agg_top_tb.sv
module irq_agg_top_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] core_evt;
    logic [4:0] periph_evt;
    logic [1:0] bus_addr;
    logic       bus_we;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic       cpu_ack;
    logic       cpu_reti;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // behavioural model state
    bit [7:0] m_core;
    bit [7:0] m_pfl;
    bit [7:0] m_pen;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_agg_top u_dut (
        .clk(clk), .rst(rst), .core_evt(core_evt), .periph_evt(periph_evt),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cpu_ack(cpu_ack), .cpu_reti(cpu_reti), .irq(irq)
    );

    function automatic bit [7:0] exp_read(input bit [1:0] a);
        case (a)
            2'd0:    return m_core;
            2'd1:    return m_pfl;
            2'd2:    return m_pen;
            default: return 8'h00;
        endcase
    endfunction

    function automatic bit exp_irq();
        bit core_any;
        bit per_any;
        core_any = (m_core[5] & m_core[2]) | (m_core[4] & m_core[1]) | (m_core[3] & m_core[0]);
        per_any  = m_core[6] & (|(m_pen & m_pfl));
        return m_core[7] & (core_any | per_any);
    endfunction

    task automatic model_update();
        bit [7:0] evmap;
        bit [7:0] nc;
        if (rst) begin
            m_core = 0; m_pfl = 0; m_pen = 0;
            return;
        end
        evmap = {periph_evt[4], periph_evt[3], periph_evt[2], periph_evt[1], 3'b000, periph_evt[0]};
        nc = m_core;
        if (bus_we && bus_addr == 2'd0) nc = bus_wdata;
        nc[2:0] = nc[2:0] | core_evt;
        if (cpu_ack)                         nc[7] = 1'b0;
        else if (cpu_reti)                   nc[7] = 1'b1;
        else if (bus_we && bus_addr == 2'd0) nc[7] = bus_wdata[7];
        else                                 nc[7] = m_core[7];
        m_core = nc;
        if (bus_we && bus_addr == 2'd1) m_pfl = bus_wdata & 8'hF1;
        m_pfl = m_pfl | evmap;
        if (bus_we && bus_addr == 2'd2) m_pen = bus_wdata & 8'hF1;
    endtask

    task automatic check(input string tag);
        bit [7:0] er;
        er = exp_read(bus_addr);
        checks++;
        if (bus_rdata !== er) begin
            errors++;
            $display("FAIL %s rdata addr %0d actual %02h expected %02h", tag, bus_addr, bus_rdata, er);
        end
        checks++;
        if (irq !== exp_irq()) begin
            errors++;
            $display("FAIL %s irq actual %0b expected %0b", tag, irq, exp_irq());
        end
    endtask

    task automatic cyc(input string tag);
        @(posedge clk);
        model_update();
        @(negedge clk);
        check(tag);
    endtask

    task automatic idle();
        core_evt = 0; periph_evt = 0; bus_we = 0; bus_wdata = 0;
        cpu_ack = 0; cpu_reti = 0;
    endtask

    task automatic wr(input bit [1:0] a, input bit [7:0] d, input string tag);
        bus_addr = a; bus_we = 1; bus_wdata = d;
        cyc(tag);
        idle();
    endtask

    task automatic rd(input bit [1:0] a, input string tag);
        bus_addr = a;
        cyc(tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle();
        bus_addr = 0;
        rst = 1;
        m_core = 0; m_pfl = 0; m_pen = 0;
        cyc("R1"); cyc("R1");
        rst = 0;
        for (int a = 0; a < 4; a++) rd(a[1:0], "R1");

        // R4 flags latch with all enables off; R9 no request
        bus_addr = 1;
        periph_evt = 5'b10101; cyc("R4_R9"); idle();
        rd(1, "R4");
        core_evt = 3'b011; cyc("R4_R9"); idle();
        rd(0, "R2_R4");
        // R5 hold over idle cycles
        repeat (3) rd(1, "R5");
        // R3 layout and unimplemented bits
        wr(1, 8'hFF, "R3");
        rd(1, "R3");
        wr(2, 8'h0E, "R3");
        rd(2, "R3");
        // R5 software clear
        wr(1, 8'h00, "R5");
        rd(1, "R5");
        wr(0, 8'h00, "R5");
        // R6 set beats same-cycle clear
        wr(1, 8'h01, "R5");
        bus_addr = 1; bus_we = 1; bus_wdata = 8'h00; periph_evt = 5'b00100;
        cyc("R6"); idle();
        rd(1, "R6");
        wr(1, 8'h00, "R6");
        // R7 core path
        wr(0, 8'hA0, "R7");
        core_evt = 3'b100; bus_addr = 0; cyc("R7"); idle();
        rd(0, "R7");
        wr(0, 8'h20, "R9");
        rd(0, "R9");
        wr(0, 8'h00, "R7");
        // R8 peripheral path
        wr(2, 8'h01, "R8");
        periph_evt = 5'b00001; bus_addr = 1; cyc("R8"); idle();
        wr(0, 8'h80, "R8");
        rd(0, "R8");
        wr(0, 8'hC0, "R8");
        rd(1, "R8");
        wr(2, 8'h00, "R8");
        rd(0, "R8");
        wr(2, 8'h01, "R8");
        // R10 strobes
        bus_addr = 0; cpu_ack = 1; cyc("R10"); idle();
        rd(0, "R10");
        cpu_reti = 1; cyc("R10"); idle();
        rd(0, "R10");
        cpu_ack = 1; cpu_reti = 1; cyc("R10"); idle();
        rd(0, "R10");
        bus_we = 1; bus_wdata = 8'hC0; cpu_ack = 1; cyc("R10"); idle();
        rd(0, "R10");
        bus_we = 1; bus_wdata = 8'h40; cpu_reti = 1; cyc("R10"); idle();
        rd(0, "R10");
        // R9 global off blocks everything
        wr(0, 8'h78, "R9");
        core_evt = 3'b111; periph_evt = 5'b11111; cyc("R9"); idle();
        rd(0, "R9");
        wr(2, 8'hF1, "R9");
        rd(1, "R9");
        // R11 address 3
        wr(3, 8'hFF, "R11");
        for (int a = 0; a < 4; a++) rd(a[1:0], "R11");
        // mixed traffic
        for (int k = 0; k < 40; k++) begin
            bus_addr   = k[1:0];
            bus_we     = (k % 3) == 0;
            bus_wdata  = 8'(k * 37 + 5);
            core_evt   = 3'(k % 5 == 1 ? k : 0);
            periph_evt = 5'(k % 4 == 2 ? k : 0);
            cpu_ack    = (k % 7) == 3;
            cpu_reti   = (k % 6) == 4;
            cyc("R4_R8");
            idle();
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule